// File: doc/BRIEF.md
# Register Preload and Security Controller

This block serves the test and configuration port of a small programmable logic device. A single command port carries an opcode, an address and a write byte, with a valid/ready handshake and a registered response. Through it the host can force every output register of the device to a chosen pattern, read and write the configuration fuse words, and read and write an eight-byte user signature.

A one-time security bit guards the design. Once it is set, fuse readback and register preload are refused. The signature stays reachable in both directions. The bit takes hold on the very next command, so it belongs at the end of a programming sequence. Only a full erase, which also wipes the fuse words, clears it again. The fuse and signature storage are plain registers here.

The output register bank sits inside the block. On every clock each register takes its functional next-state bit. A preload strobe replaces that update for one cycle with the chosen pattern.

Top module: `tport_ctrl`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_valid` and `pl_strobe` are 0, every bit of `reg_q` is 0, the security bit is clear, and all fuse words and signature bytes read as zero.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1. For the following cycle exactly, `rsp_valid` is 1 and `cmd_ready` is 0. After that the port is ready again, so only one command is ever in flight.
- R3: The `cmd_op` encodings are:
  - 0: no operation
  - 1: preload
  - 2: fuse read
  - 3: fuse write
  - 4: signature read
  - 5: signature write
  - 6: set security
  - 7: full erase
- R4: A fuse write stores `cmd_wdata` at fuse word `cmd_addr[3:0]`. A later fuse read of that word returns it on `rsp_rdata` with `rsp_err` 0, provided the part is not secured.
- R5: The signature is eight bytes selected by `cmd_addr[2:0]`. Writes store `cmd_wdata[7:0]`. Reads return the byte with `rsp_err` 0 whether or not the security bit is set.
- R6: An accepted preload on an unsecured part behaves as follows:
  - `pl_strobe` is raised for the response cycle, with `pl_vec` equal to `cmd_wdata`.
  - At the next edge each bit of `reg_q` takes its own `pl_vec` bit, high or low, in place of `reg_d`.
- R7: In every cycle without `pl_strobe`, `reg_q` takes the value `reg_d` had at the previous edge.
- R8: Set security takes effect at its own acceptance edge, so the very next command already sees the part secured.
- R9: A fuse read on a secured part returns `rsp_rdata` all zeros with `rsp_err` 1, only in its single response cycle.
- R10: A preload on a secured part raises no strobe and leaves `reg_q` following `reg_d`. Its response carries `rsp_err` 1.
- R11: A full erase clears the security bit and every fuse word, and leaves the signature bytes untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Port can take a command |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W (4) | Fuse word or signature byte address |
| cmd_wdata | input | DATA_W (8) | Write data or preload pattern |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_rdata | output | DATA_W (8) | Read data, zero when refused |
| rsp_err | output | 1 | Command refused by security |
| reg_d | input | NUM_REGS (8) | Functional next state of the output registers |
| reg_q | output | NUM_REGS (8) | Output register bank |
| pl_vec | output | NUM_REGS (8) | Preload pattern towards the bank |
| pl_strobe | output | 1 | Preload apply strobe |

## Verification
The bench sets the security bit and then issues a fuse read and a preload straight after it. A design that latched the bit one cycle late would leak the fuse word or force the registers. It reads the signature while secured; a design that blocked every read behind the security bit would return zero with an error. The preload pattern is chosen against an all-ones functional input with mixed high and low bits, and the bench watches the cycle after the strobe. This catches a bank that ignores the override, fails to release it, or forces only one polarity. A fuse read after erase, paired with a signature read, catches an erase that spares the fuses or clears the signature too.

// File: rtl/tport_pkg.sv
package tport_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_PRELOAD = 3'd1,
      OP_FUSE_RD = 3'd2,
      OP_FUSE_WR = 3'd3,
      OP_SIG_RD  = 3'd4,
      OP_SIG_WR  = 3'd5,
      OP_SECURE  = 3'd6,
      OP_ERASE   = 3'd7
   } tport_op_e;

   localparam int SIG_BYTES = 8;
   localparam int SIG_AW    = 3;
   localparam int SIG_BW    = 8;
endpackage

// File: rtl/tport_store.sv
module tport_store #(
   parameter int DATA_W     = 8,
   parameter int FUSE_WORDS = 16,
   parameter int FA_W       = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fuse_we,
   input  logic                        fuse_clr,
   input  logic                        sig_we,
   input  logic [FA_W-1:0]             fuse_addr,
   input  logic [tport_pkg::SIG_AW-1:0] sig_addr,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           fuse_rd,
   output logic [DATA_W-1:0]           sig_rd
);
   import tport_pkg::*;

   logic [DATA_W-1:0] fuse_mem [FUSE_WORDS];
   logic [SIG_BW-1:0] sig_mem  [SIG_BYTES];

   // one storage word per generate slice, each with its own write decode
   for (genvar w = 0; w < FUSE_WORDS; w++) begin : g_fuse
      always_ff @(posedge clk) begin
         if (!rst_n || fuse_clr)
            fuse_mem[w] <= '0;
         else if (fuse_we && fuse_addr == FA_W'(w))
            fuse_mem[w] <= wdata;
      end
   end

   for (genvar b = 0; b < SIG_BYTES; b++) begin : g_sig
      always_ff @(posedge clk) begin
         if (!rst_n)
            sig_mem[b] <= '0;
         else if (sig_we && sig_addr == SIG_AW'(b))
            sig_mem[b] <= wdata[SIG_BW-1:0];
      end
   end

   assign fuse_rd = fuse_mem[fuse_addr];
   assign sig_rd  = DATA_W'(sig_mem[sig_addr]);
endmodule

// File: rtl/tport_seq.sv
module tport_seq #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [2:0]          cmd_op,
   input  logic [DATA_W-1:0]   cmd_wdata,
   input  logic [DATA_W-1:0]   fuse_rd,
   input  logic [DATA_W-1:0]   sig_rd,
   output logic                fuse_we,
   output logic                fuse_clr,
   output logic                sig_we,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                rsp_err,
   output logic [NUM_REGS-1:0] pl_vec,
   output logic                pl_strobe,
   output logic                secured
);
   import tport_pkg::*;

   tport_op_e op;
   logic      busy_q;
   logic      accept;

   assign op        = tport_op_e'(cmd_op);
   assign cmd_ready = !busy_q;
   assign accept    = cmd_valid && !busy_q;

   always_comb begin
      fuse_we  = accept && (op == OP_FUSE_WR);
      sig_we   = accept && (op == OP_SIG_WR);
      fuse_clr = accept && (op == OP_ERASE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
         pl_strobe <= 1'b0;
         pl_vec    <= '0;
         secured   <= 1'b0;
      end else begin
         busy_q    <= accept;
         rsp_valid <= accept;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
         pl_strobe <= 1'b0;
         if (accept) begin
            unique case (op)
               OP_FUSE_RD: begin
                  if (secured) rsp_err   <= 1'b1;
                  else         rsp_rdata <= fuse_rd;
               end
               OP_SIG_RD:  rsp_rdata <= sig_rd;
               OP_PRELOAD: begin
                  if (secured) begin
                     rsp_err <= 1'b1;
                  end else begin
                     pl_strobe <= 1'b1;
                     pl_vec    <= cmd_wdata[NUM_REGS-1:0];
                  end
               end
               OP_SECURE:  secured <= 1'b1;
               OP_ERASE:   secured <= 1'b0;
               default:    ;
            endcase
         end
      end
   end
endmodule

// File: rtl/tport_regbank.sv
module tport_regbank #(
   parameter int                  NUM_REGS = 8,
   parameter logic [NUM_REGS-1:0] RST_VAL  = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] reg_d,
   input  logic [NUM_REGS-1:0] pl_vec,
   input  logic                pl_strobe,
   output logic [NUM_REGS-1:0] reg_q
);
   // each output register is its own flop; preload overrides the functional input
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)         reg_q[i] <= RST_VAL[i];
         else if (pl_strobe) reg_q[i] <= pl_vec[i];
         else                reg_q[i] <= reg_d[i];
      end
   end
endmodule

// File: rtl/tport_ctrl.sv
module tport_ctrl #(
   parameter int                  NUM_REGS   = 8,
   parameter int                  DATA_W     = 8,
   parameter int                  FUSE_WORDS = 16,
   parameter logic [NUM_REGS-1:0] REG_RST    = '0,
   localparam int                 FA_W       = $clog2(FUSE_WORDS),
   localparam int                 ADDR_W     = (FA_W > tport_pkg::SIG_AW) ? FA_W : tport_pkg::SIG_AW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [2:0]          cmd_op,
   input  logic [ADDR_W-1:0]   cmd_addr,
   input  logic [DATA_W-1:0]   cmd_wdata,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                rsp_err,
   input  logic [NUM_REGS-1:0] reg_d,
   output logic [NUM_REGS-1:0] reg_q,
   output logic [NUM_REGS-1:0] pl_vec,
   output logic                pl_strobe
);
   import tport_pkg::*;

   if (NUM_REGS < 1 || NUM_REGS > DATA_W) begin : g_bad_regs
      $error("NUM_REGS must lie between 1 and DATA_W");
   end
   if (DATA_W < SIG_BW) begin : g_bad_width
      $error("DATA_W must hold a signature byte");
   end
   if (FUSE_WORDS < 2 || (1 << FA_W) != FUSE_WORDS) begin : g_bad_fuse
      $error("FUSE_WORDS must be a power of two of at least 2");
   end

   logic              fuse_we, fuse_clr, sig_we, secured;
   logic [DATA_W-1:0] fuse_rd, sig_rd;

   tport_seq #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_wdata(cmd_wdata), .fuse_rd(fuse_rd), .sig_rd(sig_rd),
      .fuse_we(fuse_we), .fuse_clr(fuse_clr), .sig_we(sig_we),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .pl_vec(pl_vec), .pl_strobe(pl_strobe), .secured(secured)
   );

   tport_store #(.DATA_W(DATA_W), .FUSE_WORDS(FUSE_WORDS), .FA_W(FA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .fuse_we(fuse_we), .fuse_clr(fuse_clr), .sig_we(sig_we),
      .fuse_addr(cmd_addr[FA_W-1:0]), .sig_addr(cmd_addr[SIG_AW-1:0]),
      .wdata(cmd_wdata), .fuse_rd(fuse_rd), .sig_rd(sig_rd)
   );

   tport_regbank #(.NUM_REGS(NUM_REGS), .RST_VAL(REG_RST)) u_bank (
      .clk(clk), .rst_n(rst_n), .reg_d(reg_d),
      .pl_vec(pl_vec), .pl_strobe(pl_strobe), .reg_q(reg_q)
   );
endmodule

// File: rtl/tport_ctrl_chk.sv
module tport_ctrl_chk #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_valid,
   input logic                cmd_ready,
   input logic [2:0]          cmd_op,
   input logic                rsp_valid,
   input logic [DATA_W-1:0]   rsp_rdata,
   input logic                rsp_err,
   input logic [NUM_REGS-1:0] reg_d,
   input logic [NUM_REGS-1:0] reg_q,
   input logic [NUM_REGS-1:0] pl_vec,
   input logic                pl_strobe,
   input logic                secured
);
   logic take;
   assign take = cmd_valid && cmd_ready;

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (rsp_valid && !cmd_ready));
   assert_rsp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && cmd_ready));
   assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> !rsp_valid);
   assert_preload_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pl_strobe |=> (reg_q == $past(pl_vec)));
   assert_strobe_with_ok_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pl_strobe |-> (rsp_valid && !rsp_err));
   assert_follow_d_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pl_strobe |=> (reg_q == $past(reg_d)));
   assert_secure_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cmd_op == 3'd6) |=> secured);
   assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0));
   assert_locked_preload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && secured && cmd_op == 3'd1) |=> (!pl_strobe && rsp_err));
   assert_erase_unlocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cmd_op == 3'd7) |=> !secured);
endmodule

bind tport_ctrl tport_ctrl_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
   .rsp_err(rsp_err), .reg_d(reg_d), .reg_q(reg_q), .pl_vec(pl_vec),
   .pl_strobe(pl_strobe), .secured(secured)
);

// File: tb/tport_ctrl_bench.sv
`timescale 1ns/1ps
module tport_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [2:0] cmd_op = 3'd0;
   logic [3:0] cmd_addr = 4'd0;
   logic [7:0] cmd_wdata = 8'd0;
   logic       rsp_valid, rsp_err, pl_strobe;
   logic [7:0] rsp_rdata, reg_q, pl_vec;
   logic [7:0] reg_d = 8'hFF;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   tport_ctrl u_tport_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .reg_d(reg_d), .reg_q(reg_q), .pl_vec(pl_vec), .pl_strobe(pl_strobe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // issues one command from a falling edge; returns at the falling edge after the response
   task automatic run_cmd(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output logic er,
                          output logic st, output logic [7:0] pv);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
      @(posedge clk);
      @(negedge clk);
      chk("R2 rsp_valid in response cycle", 32'(rsp_valid), 32'd1);
      chk("R2 cmd_ready low while busy", 32'(cmd_ready), 32'd0);
      rd = rsp_rdata; er = rsp_err; st = pl_strobe; pv = pl_vec;
      cmd_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R2 ready again, response gone", 32'({cmd_ready, rsp_valid}), 32'b10);
   endtask

   // op, addr, wdata, expected rdata, expected err
   localparam logic [23:0] VEC [15] = '{
      {3'd3, 4'h3, 8'h5A, 8'h00, 1'b0},
      {3'd3, 4'hF, 8'hC3, 8'h00, 1'b0},
      {3'd2, 4'h3, 8'h00, 8'h5A, 1'b0},
      {3'd2, 4'hF, 8'h00, 8'hC3, 1'b0},
      {3'd2, 4'h0, 8'h00, 8'h00, 1'b0},
      {3'd5, 4'h0, 8'h11, 8'h00, 1'b0},
      {3'd5, 4'h7, 8'hE7, 8'h00, 1'b0},
      {3'd4, 4'h7, 8'h00, 8'hE7, 1'b0},
      {3'd4, 4'h0, 8'h00, 8'h11, 1'b0},
      {3'd6, 4'h0, 8'h00, 8'h00, 1'b0},
      {3'd2, 4'h3, 8'h00, 8'h00, 1'b1},
      {3'd4, 4'h7, 8'h00, 8'hE7, 1'b0},
      {3'd7, 4'h0, 8'h00, 8'h00, 1'b0},
      {3'd2, 4'h3, 8'h00, 8'h00, 1'b0},
      {3'd4, 4'h0, 8'h00, 8'h11, 1'b0}
   };

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] rd, pv;
      logic       er, st;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 reg_q cleared", 32'(reg_q), 32'h00);
      chk("R1 ready/valid/strobe", 32'({cmd_ready, rsp_valid, pl_strobe}), 32'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", 32'({cmd_ready, rsp_valid, rsp_err}), 32'b100);
      chk("R7 reg_q follows reg_d", 32'(reg_q), 32'hFF);

      run_cmd(3'd2, 4'h9, 8'h00, rd, er, st, pv);
      chk("R1 fuse word zero after reset", 32'({rd, er}), 32'({8'h00, 1'b0}));
      run_cmd(3'd4, 4'h5, 8'h00, rd, er, st, pv);
      chk("R1 signature zero after reset", 32'({rd, er}), 32'({8'h00, 1'b0}));

      // table: R3 R4 R5 R8 R9 R11
      for (int i = 0; i < 15; i++) begin
         run_cmd(VEC[i][23:21], VEC[i][20:17], VEC[i][16:9], rd, er, st, pv);
         chk($sformatf("R4/R5/R9/R11 vector %0d rdata", i), 32'(rd), 32'(VEC[i][8:1]));
         chk($sformatf("R3/R8/R9 vector %0d err", i), 32'(er), 32'(VEC[i][0]));
      end

      // R6: preload with mixed high and low bits against an all-ones functional input
      reg_d = 8'hFF;
      run_cmd(3'd1, 4'h0, 8'h35, rd, er, st, pv);
      chk("R6 strobe and pattern", 32'({st, pv, er}), 32'({1'b1, 8'h35, 1'b0}));
      chk("R6 registers preloaded", 32'(reg_q), 32'h35);
      @(negedge clk);
      chk("R7 normal update resumes", 32'(reg_q), 32'hFF);
      run_cmd(3'd1, 4'h0, 8'hCA, rd, er, st, pv);
      chk("R6 opposite pattern", 32'(reg_q), 32'hCA);

      // R8, R9, R10: secure, then at once a refused fuse read and preload
      run_cmd(3'd3, 4'h6, 8'h77, rd, er, st, pv);
      reg_d = 8'h0F;
      run_cmd(3'd6, 4'h0, 8'h00, rd, er, st, pv);
      run_cmd(3'd2, 4'h6, 8'h00, rd, er, st, pv);
      chk("R8 R9 secured fuse read refused", 32'({rd, er}), 32'({8'h00, 1'b1}));
      run_cmd(3'd1, 4'h0, 8'hA5, rd, er, st, pv);
      chk("R10 no strobe, error", 32'({st, er}), 32'b01);
      chk("R10 registers untouched", 32'(reg_q), 32'h0F);
      run_cmd(3'd5, 4'h2, 8'h3C, rd, er, st, pv);
      run_cmd(3'd4, 4'h2, 8'h00, rd, er, st, pv);
      chk("R5 signature written and read while secured", 32'({rd, er}), 32'({8'h3C, 1'b0}));

      // R11: erase clears fuses and unlocks preload
      run_cmd(3'd7, 4'h0, 8'h00, rd, er, st, pv);
      run_cmd(3'd2, 4'h6, 8'h00, rd, er, st, pv);
      chk("R11 fuse cleared by erase", 32'({rd, er}), 32'({8'h00, 1'b0}));
      run_cmd(3'd1, 4'h0, 8'h5A, rd, er, st, pv);
      chk("R11 preload allowed after erase", 32'(reg_q), 32'h5A);
      run_cmd(3'd4, 4'h2, 8'h00, rd, er, st, pv);
      chk("R11 signature kept by erase", 32'(rd), 32'h3C);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule